// File: doc/BRIEF.md
# Oversampled Three-State Phase-Frequency Detector

This block compares the rising edges of a reference clock and a divided feedback clock and produces the up and down pulses that steer a charge pump in a frequency synthesizer loop. Both clocks are treated as data. They are sampled on a fast oversampling clock, passed through a synchronizer and turned into one-cycle rise events. Only the positions of those edges matter. The width or duty cycle of the input pulses has no effect.

The detector has three classic states: idle, up active and down active. An edge on one input raises that input's output. The output stays raised until the edge on the other input arrives. At that point both outputs are high together. Instead of clearing them at once, the block holds them high for a programmable number of oversampling cycles. This removes the dead zone, so very small phase errors still produce a measurable pulse on both lines. An edge that arrives while this overlap is running is remembered and acted on in the cycle after the overlap ends. The current state is exported for observation.

Top module: `pfd_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is idle: `up_o`=0, `dn_o`=0, `state_o`=0.
- R2: A reference rising edge seen in the idle state raises `up_o` (and only `up_o`) 3 clock cycles after the new input level is first present at a rising edge. `up_o` stays high until a feedback edge arrives.
- R3: A feedback rising edge seen in the idle state raises `dn_o` only, with the same 3-cycle latency, and holds it until a reference edge arrives.
- R4: When the second input's edge arrives, both outputs are high for exactly N clock cycles, where N is `ovl_cycles_i` (1 to 15) sampled as the overlap starts. After that both clear and the state returns to idle.
- R5: Reference and feedback edges that are detected in the same cycle go straight into the N-cycle overlap.
- R6: An `ovl_cycles_i` value of 0 behaves as 1.
- R7: A further reference edge while `up_o` alone is active, before the feedback edge, has no effect on either output.
- R8: Input pulse width and duty cycle do not affect the outputs; only rising edges count.
- R9: An edge detected during the overlap is latched. In the first cycle after the overlap, its output is asserted alone (if only one side is pending), or a new overlap starts (if both sides are pending).
- R10: `state_o` encodes the state as 0 = idle, 1 = up only, 2 = down only, 3 = overlap. It always agrees with `up_o`/`dn_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference clock, sampled as data |
| fb_i | input | 1 | Divided feedback clock, sampled as data |
| ovl_cycles_i | input | DLY_W (4) | Overlap length in clock cycles (0 treated as 1) |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| state_o | output | 2 | Detector state code |

## Verification
The bench builds the block with the default 4-bit overlap field and a two-stage synchronizer. This makes every overlap length from 0 to 15 reachable in an exhaustive sweep. For each length the bench steps the feedback edge through a window from six cycles early to six cycles late. It also varies the pulse widths, so reference-first, feedback-first and coincident ordering are all covered. A second sweep slides an extra reference edge from before the feedback edge to past the end of the overlap. This reaches the ignored-edge case, the latched-during-overlap case, the exact final-cycle boundary and the plain re-arm from idle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int DLY_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2,
        ST_OVL  = 2'd3
    } pfd_state_e;

    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } pfd_events_t;

    // Counter preload for an overlap of 'len' cycles; a zero request acts as one.
    function automatic logic [DLY_W-1:0] ovl_preload(input logic [DLY_W-1:0] len);
        logic [DLY_W-1:0] eff;
        eff = (len == '0) ? DLY_W'(1) : len;
        return eff - DLY_W'(1);
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sig_i};
            hist_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~hist_q;

    // R8
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pfd_events_t      ev_i,
    input  logic [DLY_W-1:0] ovl_cycles_i,
    output pfd_state_e       state_o
);
    pfd_state_e       st_q, st_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             pend_r_q, pend_r_d, pend_f_q, pend_f_d;
    logic             any_r, any_f;

    assign any_r = pend_r_q | ev_i.ref_rise;
    assign any_f = pend_f_q | ev_i.fb_rise;

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        pend_r_d = pend_r_q;
        pend_f_d = pend_f_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ev_i.ref_rise && ev_i.fb_rise) begin
                    st_d  = ST_OVL;
                    cnt_d = ovl_preload(ovl_cycles_i);
                end else if (ev_i.ref_rise) begin
                    st_d = ST_UP;
                end else if (ev_i.fb_rise) begin
                    st_d = ST_DN;
                end
            end
            ST_UP: begin
                if (ev_i.fb_rise) begin
                    st_d  = ST_OVL;
                    cnt_d = ovl_preload(ovl_cycles_i);
                end
            end
            ST_DN: begin
                if (ev_i.ref_rise) begin
                    st_d  = ST_OVL;
                    cnt_d = ovl_preload(ovl_cycles_i);
                end
            end
            ST_OVL: begin
                if (cnt_q == '0) begin
                    pend_r_d = 1'b0;
                    pend_f_d = 1'b0;
                    if (any_r && any_f) begin
                        st_d  = ST_OVL;
                        cnt_d = ovl_preload(ovl_cycles_i);
                    end else if (any_r) begin
                        st_d = ST_UP;
                    end else if (any_f) begin
                        st_d = ST_DN;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else begin
                    cnt_d    = cnt_q - DLY_W'(1);
                    pend_r_d = any_r;
                    pend_f_d = any_f;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            pend_r_q <= 1'b0;
            pend_f_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            pend_r_q <= pend_r_d;
            pend_f_q <= pend_f_d;
        end
    end

    assign state_o = st_q;

    // R2
    up_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_UP && !ev_i.fb_rise) |=> (st_q == ST_UP));

    // R4
    ovl_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_UP && ev_i.fb_rise) |=> (st_q == ST_OVL));

    // R4
    ovl_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OVL && cnt_q == '0 && !any_r && !any_f) |=> (st_q == ST_IDLE));

    // R9
    pend_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OVL && cnt_q == '0 && any_r && !any_f) |=> (st_q == ST_UP));

endmodule

// File: rtl/pfd_top.sv
module pfd_top
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_i,
    input  logic             fb_i,
    input  logic [DLY_W-1:0] ovl_cycles_i,
    output logic             up_o,
    output logic             dn_o,
    output logic [1:0]       state_o
);
    localparam int N_CH = 2;

    logic [N_CH-1:0] raw_w;
    logic [N_CH-1:0] rise_w;
    pfd_events_t     ev_w;
    pfd_state_e      st_w;

    assign raw_w = {fb_i, ref_i};

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_edge
        pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
            .clk    (clk),
            .rst    (rst),
            .sig_i  (raw_w[gi]),
            .rise_o (rise_w[gi])
        );
    end

    assign ev_w.ref_rise = rise_w[0];
    assign ev_w.fb_rise  = rise_w[1];

    pfd_core i_core (
        .clk          (clk),
        .rst          (rst),
        .ev_i         (ev_w),
        .ovl_cycles_i (ovl_cycles_i),
        .state_o      (st_w)
    );

    assign up_o    = (st_w == ST_UP) || (st_w == ST_OVL);
    assign dn_o    = (st_w == ST_DN) || (st_w == ST_OVL);
    assign state_o = st_w;

    // R10
    out_code_chk: assert property (@(posedge clk) disable iff (rst)
        (up_o && dn_o) |-> (state_o == 2'd3));

endmodule

// File: tb/test_pfd_top.sv
module test_pfd_top;
    localparam int WIN = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_i = 1'b0;
    logic       fb_i = 1'b0;
    logic [3:0] ovl = 4'd1;
    logic       up_o, dn_o;
    logic [1:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pfd_top i_pfd_top (
        .clk(clk), .rst(rst), .ref_i(ref_i), .fb_i(fb_i),
        .ovl_cycles_i(ovl), .up_o(up_o), .dn_o(dn_o), .state_o(state_o)
    );

    task automatic check(string tag, int k, bit eu, bit ed);
        logic [1:0] es;
        es = {ed, eu};
        n_chk++;
        if (up_o !== eu || dn_o !== ed || state_o !== es) begin
            n_bad++;
            $display("FAIL %s cycle %0d: up/dn/state actual %0b/%0b/%0d expected %0b/%0b/%0d",
                     tag, k, up_o, dn_o, state_o, eu, ed, es);
        end
    endtask

    // a: ref edge cycle, b: fb edge cycle, a2: extra ref edge (-1 none)
    task automatic run(int a, int b, int a2, int wr, int wb, int n, string tag);
        int ne, ov_s, ov_e, re_from;
        bit eu, ed;
        string t;
        ne   = (n == 0) ? 1 : n;
        ov_s = ((a > b) ? a : b) + 3;
        ov_e = ov_s + ne - 1;
        re_from = (a2 + 3 > ov_e + 1) ? a2 + 3 : ov_e + 1;
        @(negedge clk);
        rst = 1'b1; ref_i = 1'b0; fb_i = 1'b0; ovl = 4'(n);
        @(negedge clk);
        @(negedge clk);
        check("R1", -1, 1'b0, 1'b0);
        rst = 1'b0;
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            eu = (k >= a + 3 && k <= ov_e) || (a2 >= 0 && a2 > b && k >= re_from);
            ed = (k >= b + 3 && k <= ov_e);
            t  = (k >= ov_s && k <= ov_e) ? "R4" : tag;
            check(t, k, eu, ed);
            ref_i = (k >= a && k < a + wr) || (a2 >= 0 && k == a2);
            fb_i  = (k >= b && k < b + wb);
        end
    endtask

    initial begin
        string tg;
        // sweep over every overlap length and edge ordering
        for (int n = 0; n < 16; n++) begin
            for (int d = -6; d <= 6; d++) begin
                int wr, wb;
                wr = 1 + (n + d + 6) % 9;
                wb = 1 + (n * 3 + d + 6) % 11;
                if (d == 0)      tg = "R5";
                else if (n == 0) tg = "R6";
                else if (wr > 4) tg = "R8";
                else if (d > 0)  tg = "R2";
                else             tg = "R3";
                run(10, 10 + d, -1, wr, wb, n, tg);
            end
        end
        // extra reference edge: ignored before fb (R7), latched in overlap (R9)
        for (int n = 1; n < 16; n += 7) begin
            for (int a2 = 9; a2 <= 12 + n + 3; a2++) begin
                tg = (a2 <= 12) ? "R7" : "R9";
                run(4, 12, a2, 1, 3, n, tg);
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule